// File: doc/BRIEF.md
# Programmable Repeating Pulse Generator

This block is one timing channel. A divide-by-N prescaler turns one of two clock-enable sources into a count tick. A 20-bit counter advances on that tick and wraps at a programmed cycle length. The output is high while the count lies between a programmed start value (inclusive) and end value (exclusive). The channel runs a programmed number of cycles and then stops with its output low. A repeat count of zero makes it run until reset.

An external clear input is synchronized inside the block. Depending on the clear mode, it either holds the channel at count zero while a level is present, or restarts a whole new burst on a chosen edge. With an edge mode and a single repeat, each edge on the clear input produces one pulse delayed by the start value. This makes the channel a trigger-delay element.

Settings arrive through a plain write strobe into pending registers. They reach the running channel only while it is stopped or held in clear, when it is restarted, or at the wrap of a cycle. Writing the repeat register while the channel is stopped starts a new burst.

Top module: `rpt_pulse_gen`

## Requirements
- R1: After reset the channel is stopped and `pulse_out` is low, and it stays low until the channel is started. The reset settings are: length 1, start 0, end 1, repeat 1, clear mode 0, divider 0, source 0.
- R2: A write to the repeat register (address 3, count in bits 7:0) while the channel is stopped applies all pending settings, including that write, and starts a burst at count 0 on the same clock edge. The same write while the channel is running changes only the pending value and does not restart the channel.
- R3: `pulse_out` is high exactly when the count is at least the start value (address 1) and below the end value (address 2). It shows the count of the previous clock, so it lags by one cycle. If start is not below end, the output never goes high.
- R4: The count wraps to 0 on the tick that would take it to the cycle length (address 0, bits 19:0). A length of 0 behaves like 1.
- R5: A repeat count N from 1 to 255 gives exactly N cycles, after which the channel stops with the output low. A count of 0 repeats without end.
- R6: The counter advances once every D+1 enabled source cycles, where D is the divider value (address 5, bits 11:0). D = 0 advances on every enabled cycle, and D = 0xFFF advances once every 4096 enabled cycles. The prescaler phase restarts with every burst.
- R7: The source register (address 6, bit 0) selects `ref_en` when 0 and `pix_en` when 1. The enable that is not selected has no effect on the count.
- R8: Clear mode 4 (rising edge) or 8 (falling edge), in the mode register at address 4, bits 3:0, restarts the count at 0 and reloads the repeat count, whether the channel is running or stopped. The input passes through two synchronizer stages, so an edge on `clr_in` just after clock edge k restarts the channel at edge k+3. The opposite edge is ignored.
- R9: Clear mode 1 (hold while high) or 2 (hold while low) keeps the count at 0 and the output low while the level is present. Counting of a fresh burst resumes on the first tick after release. A release just after edge k makes edge k+2 the start of the burst.
- R10: Clear mode values other than 1, 2, 4 and 8 act as free run, and `clr_in` has no effect on the output.
- R11: A setting written while the channel is running takes effect from the next cycle wrap. The cycle in progress keeps the old setting.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for all state |
| rst_n | input | 1 | Synchronous reset, active low |
| ref_en | input | 1 | Clock-enable from the fixed reference (source 0) |
| pix_en | input | 1 | Clock-enable from the pixel clock (source 1) |
| clr_in | input | 1 | External clear / restart input, asynchronous |
| wr_en | input | 1 | Write strobe for the setting registers |
| wr_addr | input | 3 | Register address of the write |
| wr_data | input | 20 | Write data, right-aligned |
| pulse_out | output | 1 | Registered pulse output |

## Verification
The bench builds the block with its default widths: a 20-bit counter, a 12-bit divider and an 8-bit repeat count. Because the widths are the real ones, the divide-by-4096 extreme can be checked cycle by cycle over a short three-tick cycle, and a 1000-tick cycle with a 400-tick pulse can be checked in full. Lengths, windows and repeat counts in the random part stay small, so each burst runs through many wraps and stops. This keeps the one-cycle output lag, the three-stage edge latency and the wrap-time setting update visible within a few thousand cycles.

// File: rtl/pgen_pkg.sv
`timescale 1ns/1ps
// Shared constants for the repeating pulse generator: register addresses
// and clear-mode codes. Assumes a 3-bit word address on the write port.
package pgen_pkg;
    localparam int ADDR_W = 3;
    localparam int MODE_W = 4;

    localparam logic [ADDR_W-1:0] A_LEN    = 3'd0;
    localparam logic [ADDR_W-1:0] A_START  = 3'd1;
    localparam logic [ADDR_W-1:0] A_STOP   = 3'd2;
    localparam logic [ADDR_W-1:0] A_REPEAT = 3'd3;
    localparam logic [ADDR_W-1:0] A_MODE   = 3'd4;
    localparam logic [ADDR_W-1:0] A_DIV    = 3'd5;
    localparam logic [ADDR_W-1:0] A_SRC    = 3'd6;

    localparam logic [MODE_W-1:0] CM_FREE = 4'd0;
    localparam logic [MODE_W-1:0] CM_HIGH = 4'd1;
    localparam logic [MODE_W-1:0] CM_LOW  = 4'd2;
    localparam logic [MODE_W-1:0] CM_RISE = 4'd4;
    localparam logic [MODE_W-1:0] CM_FALL = 4'd8;
endpackage

// File: rtl/pgen_regs.sv
`timescale 1ns/1ps
// Pending setting registers. Holds the values written over the strobe
// port and presents them merged with a write of the current cycle, so
// the channel core can adopt a setting on the same edge it is written.
// Assumes wr_data is at least as wide as every field.
module pgen_regs
    import pgen_pkg::*;
#(
    parameter int CNT_W = 20,
    parameter int DIV_W = 12,
    parameter int REP_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    output logic [CNT_W-1:0]  nx_len,
    output logic [CNT_W-1:0]  nx_start,
    output logic [CNT_W-1:0]  nx_stop,
    output logic [REP_W-1:0]  nx_rep,
    output logic [MODE_W-1:0] nx_mode,
    output logic [DIV_W-1:0]  nx_div,
    output logic              nx_src,
    output logic              arm_wr
);
    logic [CNT_W-1:0]  sh_len, sh_start, sh_stop;
    logic [REP_W-1:0]  sh_rep;
    logic [MODE_W-1:0] sh_mode;
    logic [DIV_W-1:0]  sh_div;
    logic              sh_src;

    // Merge the write of this cycle over the stored pending values.
    always_comb begin
        nx_len   = sh_len;
        nx_start = sh_start;
        nx_stop  = sh_stop;
        nx_rep   = sh_rep;
        nx_mode  = sh_mode;
        nx_div   = sh_div;
        nx_src   = sh_src;
        if (wr_en) begin
            case (wr_addr)
                A_LEN:    nx_len   = wr_data;
                A_START:  nx_start = wr_data;
                A_STOP:   nx_stop  = wr_data;
                A_REPEAT: nx_rep   = wr_data[REP_W-1:0];
                A_MODE:   nx_mode  = wr_data[MODE_W-1:0];
                A_DIV:    nx_div   = wr_data[DIV_W-1:0];
                A_SRC:    nx_src   = wr_data[0];
                default:  ;
            endcase
        end
    end

    assign arm_wr = wr_en && (wr_addr == A_REPEAT);

    // Store the merged values; reset gives a one-tick, single-shot setup.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_len   <= CNT_W'(1);
            sh_start <= '0;
            sh_stop  <= CNT_W'(1);
            sh_rep   <= REP_W'(1);
            sh_mode  <= CM_FREE;
            sh_div   <= '0;
            sh_src   <= 1'b0;
        end else begin
            sh_len   <= nx_len;
            sh_start <= nx_start;
            sh_stop  <= nx_stop;
            sh_rep   <= nx_rep;
            sh_mode  <= nx_mode;
            sh_div   <= nx_div;
            sh_src   <= nx_src;
        end
    end
endmodule

// File: rtl/pgen_prescale.sv
`timescale 1ns/1ps
// Divide-by-(div_n+1) prescaler on a selectable clock-enable source.
// Emits a one-cycle tick. phase_clr restarts the division phase and
// suppresses the tick. Assumes div_n changes only while phase_clr is high
// or at a channel wrap.
module pgen_prescale #(
    parameter int DIV_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             src_sel,
    input  logic             ref_en,
    input  logic             pix_en,
    input  logic [DIV_W-1:0] div_n,
    input  logic             phase_clr,
    output logic             tick
);
    logic [DIV_W-1:0] dcnt_q;
    logic             src_en;
    logic             at_top;

    assign src_en = src_sel ? pix_en : ref_en;
    assign at_top = (dcnt_q >= div_n);
    assign tick   = src_en && !phase_clr && at_top;

    // Count enabled source cycles and fold back after div_n+1 of them.
    always_ff @(posedge clk) begin
        if (!rst_n || phase_clr) begin
            dcnt_q <= '0;
        end else if (src_en) begin
            dcnt_q <= at_top ? '0 : dcnt_q + DIV_W'(1);
        end
    end

    // R6: with a nonzero divider, two ticks are never adjacent.
    p_tick_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && div_n != '0) |=> (!tick || div_n == '0));
endmodule

// File: rtl/pgen_clrqual.sv
`timescale 1ns/1ps
// Clear-input qualifier: two-stage synchronizer plus an edge stage. It
// turns the selected clear mode into a level hold or a single-cycle
// restart strike. Mode codes other than the four defined ones act as free run.
module pgen_clrqual
    import pgen_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_in,
    input  logic [MODE_W-1:0] mode,
    output logic              hold,
    output logic              edge_hit
);
    logic s1_q, s2_q, s3_q;

    // Synchronize the asynchronous clear and keep one older sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_q <= 1'b0;
            s2_q <= 1'b0;
            s3_q <= 1'b0;
        end else begin
            s1_q <= clr_in;
            s2_q <= s1_q;
            s3_q <= s2_q;
        end
    end

    // Decode the mode into a hold level or an edge strike.
    always_comb begin
        hold     = 1'b0;
        edge_hit = 1'b0;
        case (mode)
            CM_HIGH: hold     = s2_q;
            CM_LOW:  hold     = !s2_q;
            CM_RISE: edge_hit = s2_q && !s3_q;
            CM_FALL: edge_hit = !s2_q && s3_q;
            default: ;
        endcase
    end

    // R8: an edge strike lasts exactly one cycle per edge.
    p_edge_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        edge_hit |=> !edge_hit);
endmodule

// File: rtl/pgen_core.sv
`timescale 1ns/1ps
// Channel core: active settings, the cycle counter, the remaining-repeat
// counter and the registered pulse output. Pending settings are adopted
// while stopped or held, on a restart, or at a wrap. The repeat counter
// uses 0 for "forever" and is reloaded only on a restart.
module pgen_core
    import pgen_pkg::*;
#(
    parameter int CNT_W = 20,
    parameter int DIV_W = 12,
    parameter int REP_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  nx_len,
    input  logic [CNT_W-1:0]  nx_start,
    input  logic [CNT_W-1:0]  nx_stop,
    input  logic [REP_W-1:0]  nx_rep,
    input  logic [MODE_W-1:0] nx_mode,
    input  logic [DIV_W-1:0]  nx_div,
    input  logic              nx_src,
    input  logic              arm_wr,
    input  logic              tick,
    input  logic              hold,
    input  logic              edge_hit,
    output logic [MODE_W-1:0] act_mode,
    output logic [DIV_W-1:0]  act_div,
    output logic              act_src,
    output logic              phase_clr,
    output logic              pulse_out
);
    logic [CNT_W-1:0] act_len, act_start, act_stop;
    logic [CNT_W-1:0] cnt_q;
    logic [REP_W-1:0] rep_q;
    logic             run_q, out_q;
    logic [CNT_W:0]   cnt_nx;
    logic             restart, wrap_now, load, in_win;

    assign restart   = (arm_wr && !run_q) || edge_hit || hold;
    assign cnt_nx    = {1'b0, cnt_q} + {{CNT_W{1'b0}}, 1'b1};
    assign wrap_now  = tick && run_q && !restart && (cnt_nx >= {1'b0, act_len});
    assign load      = !run_q || restart || wrap_now;
    assign phase_clr = !run_q || restart;
    assign in_win    = (cnt_q >= act_start) && (cnt_q < act_stop);
    assign pulse_out = out_q;

    // Adopt pending settings at the permitted moments only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_len   <= CNT_W'(1);
            act_start <= '0;
            act_stop  <= CNT_W'(1);
            act_mode  <= CM_FREE;
            act_div   <= '0;
            act_src   <= 1'b0;
        end else if (load) begin
            act_len   <= nx_len;
            act_start <= nx_start;
            act_stop  <= nx_stop;
            act_mode  <= nx_mode;
            act_div   <= nx_div;
            act_src   <= nx_src;
        end
    end

    // Run state, cycle count and remaining repeats.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= 1'b0;
            cnt_q <= '0;
            rep_q <= '0;
        end else if (restart) begin
            run_q <= 1'b1;
            cnt_q <= '0;
            rep_q <= nx_rep;
        end else if (wrap_now) begin
            cnt_q <= '0;
            if (rep_q == REP_W'(1)) begin
                run_q <= 1'b0;
            end else if (rep_q != '0) begin
                rep_q <= rep_q - REP_W'(1);
            end
        end else if (tick && run_q) begin
            cnt_q <= cnt_nx[CNT_W-1:0];
        end
    end

    // Register the window compare so the output is glitch free.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= 1'b0;
        end else begin
            out_q <= run_q && !hold && in_win;
        end
    end

    // R1: a stopped channel drives a low output on the next cycle.
    p_idle_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !run_q |=> !pulse_out);
    // R4: while running, the count stays below a nonzero cycle length.
    p_cnt_in_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && act_len != '0) |-> (cnt_q < act_len));
    // R5: once a finite burst ends, the output is low.
    p_stop_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(run_q) |=> !pulse_out);
    // R8: an edge strike leaves the channel running from count zero.
    p_edge_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
        edge_hit |=> (run_q && cnt_q == '0));
    // R9: a level hold keeps count zero and output low.
    p_hold_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> (cnt_q == '0 && !pulse_out));
endmodule

// File: rtl/rpt_pulse_gen.sv
`timescale 1ns/1ps
// Top of the repeating pulse generator channel. It wires the pending
// registers, clear qualifier, prescaler and channel core together.
// Assumes clr_in is asynchronous and the enables are synchronous to clk.
module rpt_pulse_gen
    import pgen_pkg::*;
#(
    parameter int CNT_W = 20,
    parameter int DIV_W = 12,
    parameter int REP_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ref_en,
    input  logic              pix_en,
    input  logic              clr_in,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    output logic              pulse_out
);
    logic [CNT_W-1:0]  nx_len, nx_start, nx_stop;
    logic [REP_W-1:0]  nx_rep;
    logic [MODE_W-1:0] nx_mode, act_mode;
    logic [DIV_W-1:0]  nx_div, act_div;
    logic              nx_src, act_src, arm_wr;
    logic              tick, hold, edge_hit, phase_clr;

    pgen_regs #(.CNT_W(CNT_W), .DIV_W(DIV_W), .REP_W(REP_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .nx_len(nx_len), .nx_start(nx_start),
        .nx_stop(nx_stop), .nx_rep(nx_rep), .nx_mode(nx_mode),
        .nx_div(nx_div), .nx_src(nx_src), .arm_wr(arm_wr)
    );

    pgen_clrqual u_clr (
        .clk(clk), .rst_n(rst_n), .clr_in(clr_in), .mode(act_mode),
        .hold(hold), .edge_hit(edge_hit)
    );

    pgen_prescale #(.DIV_W(DIV_W)) u_div (
        .clk(clk), .rst_n(rst_n), .src_sel(act_src), .ref_en(ref_en),
        .pix_en(pix_en), .div_n(act_div), .phase_clr(phase_clr), .tick(tick)
    );

    pgen_core #(.CNT_W(CNT_W), .DIV_W(DIV_W), .REP_W(REP_W)) u_core (
        .clk(clk), .rst_n(rst_n), .nx_len(nx_len), .nx_start(nx_start),
        .nx_stop(nx_stop), .nx_rep(nx_rep), .nx_mode(nx_mode),
        .nx_div(nx_div), .nx_src(nx_src), .arm_wr(arm_wr), .tick(tick),
        .hold(hold), .edge_hit(edge_hit), .act_mode(act_mode),
        .act_div(act_div), .act_src(act_src), .phase_clr(phase_clr),
        .pulse_out(pulse_out)
    );
endmodule

// File: tb/sim_rpt_pulse_gen.sv
`timescale 1ns/1ps
// Self-checking bench: directed corner cases plus seeded random setups,
// each compared against a timeline formula taken from the requirements.
module sim_rpt_pulse_gen;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ref_en = 1'b1, pix_en = 1'b0, clr_in = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [19:0] wr_data = '0;
    logic        pulse_out;

    int n_tests = 0, n_fail = 0, cyc = 0, cur_t = 0;
    int g_d = 1, g_l = 1, g_s0 = 0, g_s1 = 0, g_e = 1, g_r = 1;
    string g_tag = "R1";

    rpt_pulse_gen u0 (
        .clk(clk), .rst_n(rst_n), .ref_en(ref_en), .pix_en(pix_en),
        .clr_in(clr_in), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .pulse_out(pulse_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic report();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > WATCHDOG) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: run still active at cycle %0d, expected end before %0d", cyc, WATCHDOG);
            report();
            $finish;
        end
    end

    // Output expected t clock edges after the burst start edge.
    function automatic logic exp_out(int t);
        int u, k, c, pos, s;
        if (t < 1) return 1'b0;
        u = t - 1;
        k = u / g_d;
        c = k / g_l;
        pos = k % g_l;
        if (g_r != 0 && c >= g_r) return 1'b0;
        s = (c == 0) ? g_s0 : g_s1;
        return (pos >= s) && (pos < g_e);
    endfunction

    task automatic chk(input logic act, input logic exp, input string tag);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: t=%0d pulse_out=%0b expected %0b", tag, cur_t, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic step_chk();
        step();
        cur_t++;
        chk(pulse_out, exp_out(cur_t), g_tag);
    endtask

    task automatic trace(input int n);
        for (int i = 0; i < n; i++) step_chk();
    endtask

    task automatic zero_for(input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            step();
            chk(pulse_out, 1'b0, tag);
        end
    endtask

    task automatic wr(input logic [2:0] a, input int d, input bit with_chk);
        wr_addr = a;
        wr_data = 20'(d);
        wr_en = 1'b1;
        if (with_chk) step_chk(); else step();
        wr_en = 1'b0;
    endtask

    task automatic cfg(input int div, input int l, input int s, input int e,
                       input int mode, input int src);
        wr(3'd5, div, 0);
        wr(3'd0, l, 0);
        wr(3'd1, s, 0);
        wr(3'd2, e, 0);
        wr(3'd4, mode, 0);
        wr(3'd6, src, 0);
        g_d = div + 1;
        g_l = (l == 0) ? 1 : l;
        g_s0 = s;
        g_s1 = s;
        g_e = e;
    endtask

    task automatic arm(input int r);
        wr(3'd3, r, 0);
        g_r = r;
        cur_t = 0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        step();
        step();
        rst_n = 1'b1;
    endtask

    initial begin
        void'($urandom(32'd20240611));
        do_reset();

        // R1: reset state is stopped and low.
        zero_for(16, "R1 reset idle");
        // R1/R2: arm with reset settings -> one tick high, then stop.
        g_d = 1; g_l = 1; g_s0 = 0; g_s1 = 0; g_e = 1; g_tag = "R1 defaults";
        arm(1);
        trace(8);

        // R3 R4 R5: 400-tick pulse at 100 in a 1000-tick cycle, once.
        g_tag = "R3 window 100..500/1000";
        cfg(0, 1000, 100, 500, 0, 0);
        arm(1);
        trace(1010);

        // R3: start not below end never rises.
        g_tag = "R3 empty window";
        cfg(0, 10, 6, 3, 0, 0);
        arm(2);
        trace(25);

        // R4: zero length behaves as one.
        g_tag = "R4 zero length";
        cfg(0, 0, 0, 1, 0, 0);
        arm(3);
        trace(6);

        // R6: divide by 4096.
        g_tag = "R6 divide 4096";
        cfg(4095, 3, 1, 2, 0, 0);
        arm(1);
        trace(3 * 4096 + 4);

        // R11: start written mid-cycle applies from the next wrap.
        g_tag = "R11 write at wrap";
        cfg(0, 10, 2, 8, 0, 0);
        arm(2);
        trace(5);
        g_s1 = 5;
        wr(3'd1, 5, 1);
        trace(24);

        // R8: rising-edge restart, trigger delay and re-arm mid-burst.
        g_tag = "R8 rising edge";
        cfg(0, 12, 3, 6, 4, 0);
        arm(2);
        trace(30);
        clr_in = 1'b1;
        step_chk(); step_chk(); step_chk();
        cur_t = 0;
        trace(7);
        clr_in = 1'b0;               // falling edge ignored in mode 4
        trace(3);
        clr_in = 1'b1;
        step_chk(); step_chk(); step_chk();
        cur_t = 0;
        trace(30);

        // R8: falling-edge restart.
        g_tag = "R8 falling edge";
        wr(3'd4, 8, 0);
        clr_in = 1'b0;
        step_chk(); step_chk(); step_chk();
        cur_t = 0;
        trace(30);

        // R9: hold while high, then fresh burst after release.
        g_tag = "R9 level high";
        cfg(0, 6, 0, 3, 1, 0);
        arm(1);
        trace(10);
        clr_in = 1'b1;
        zero_for(22, "R9 hold high");
        clr_in = 1'b0;
        zero_for(2, "R9 release latency");
        cur_t = 0;
        trace(10);

        // R9: hold while low.
        g_tag = "R9 level low";
        wr(3'd4, 2, 0);
        zero_for(12, "R9 hold low");
        clr_in = 1'b1;
        zero_for(2, "R9 release latency low");
        cur_t = 0;
        trace(10);

        // R10: undefined mode ignores clr_in toggles.
        g_tag = "R10 mode 3 ignores clear";
        cfg(0, 6, 1, 4, 3, 0);
        arm(1);
        for (int i = 0; i < 6; i++) begin
            trace(2);
            clr_in = ~clr_in;
        end
        trace(4);
        clr_in = 1'b0;

        // R2 R3 R4 R5 R6: seeded random setups, free-run clear mode.
        for (int it = 0; it < 10; it++) begin
            int d, l, s, e, r;
            d = int'($urandom_range(0, 3));
            l = int'($urandom_range(2, 30));
            s = int'($urandom_range(0, l));
            e = int'($urandom_range(0, l + 1));
            r = int'($urandom_range(1, 3));
            g_tag = "R5 random burst";
            cfg(d, l, s, e, 0, 0);
            arm(r);
            trace(r * l * (d + 1) + 6);
        end

        // R5 R2: endless repeat; repeat write while running does not restart.
        g_tag = "R5 infinite";
        cfg(1, 8, 2, 5, 0, 0);
        arm(0);
        trace(40);
        g_tag = "R2 write while running";
        wr(3'd3, 1, 1);
        trace(60);
        do_reset();

        // R7: source 1 follows pix_en.
        g_tag = "R7 pixel source";
        ref_en = 1'b0; pix_en = 1'b1;
        cfg(0, 5, 1, 3, 0, 1);
        arm(1);
        trace(10);
        // R7: with source 1, ref_en alone does not advance the count.
        ref_en = 1'b1; pix_en = 1'b0;
        arm(1);
        zero_for(30, "R7 ref ignored on source 1");
        do_reset();
        // R7: with source 0, pix_en alone does not advance the count.
        ref_en = 1'b0; pix_en = 1'b1;
        cfg(0, 5, 1, 3, 0, 0);
        arm(1);
        zero_for(30, "R7 pix ignored on source 0");
        do_reset();
        ref_en = 1'b1; pix_en = 1'b0;
        zero_for(4, "R1 reset after run");

        report();
        $finish;
    end
endmodule